// File: doc/BRIEF.md
# One-Wire Slave ROM Command Layer

This block sits above the bit-level front end of a one-wire slave device and handles the commands that pick out one device among several on the bus. It holds a 64-bit identity code and answers five ROM commands: Read ROM, Match ROM, Skip ROM, Search ROM and Conditional Search.

The front end supplies four things: a pulse for each bus reset, received command bytes, master write bits, and strobes that mark each read slot. The block answers with the level to drive in the next read slot, where 1 means the line is released. When a command has addressed this device, the block raises `selected_o` for the memory layer. When the device has left the transaction, it raises `dropped_o`.

Three configuration inputs set the answering rules. Two source bits, when both are zero, put the device in a hidden mode in which only Match ROM and Conditional Search are answered. A polarity bit sets which level of the external condition input a Conditional Search needs.

Top module: `owr_rom_layer`

## Requirements
- R1: After `rst_ni` low or a `bus_rst_i` pulse, the block waits for a command byte with `selected_o`=0, `dropped_o`=0 and `rbit_o`=1.
- R2: The identity, from its least significant bit, is laid out as follows. Bits [7:0] hold the family code 0x12. Bits [55:8] hold the `SERIAL` parameter. Bits [63:56] hold the CRC-8 of bits [55:0], computed with x^8+x^5+x^4+1, fed LSB first from a zero start (per bit: feedback = crc[0]^d, crc >>= 1, and if the feedback is 1 then crc ^= 0x8C).
- R3: Read ROM (0x33) presents identity bit k on `rbit_o` before the (k+1)-th `rslot_i` strobe, for k = 0..63 with bit 0 first. `selected_o` rises in the cycle after the 64th strobe.
- R4: Skip ROM (0xCC) raises `selected_o` in the cycle after the command byte.
- R5: Match ROM (0x55) compares 64 master write bits, LSB first, with the identity. If all 64 agree, `selected_o` rises. On the first bit that differs, `dropped_o` rises.
- R6: Search ROM (0xF0) repeats three steps for each bit k. At the first read slot, `rbit_o` gives identity bit k. At the second read slot, it gives the complement of that bit. The block then takes one write bit. A write bit that differs from identity bit k raises `dropped_o`. When the 64th bit agrees, `selected_o` rises.
- R7: Conditional Search (0xEC) runs as a Search ROM when `src_level_i` equals `cfg_i[0]`. Otherwise `dropped_o` rises in the cycle after the command byte.
- R8: When `cfg_i[2:1]`==00 (hidden mode), the codes 0x33, 0xCC and 0xF0 raise `dropped_o` instead of being answered, while 0x55 and 0xEC keep their normal behaviour. A byte outside the five codes raises `dropped_o` in every mode.
- R9: While `dropped_o` is 1, byte, write-bit and read-slot strobes have no effect until a bus reset. `dropped_o` stays 1, `selected_o` stays 0 and `rbit_o` stays 1.
- R10: While `selected_o` is 1, further byte, write-bit and read-slot strobes leave `selected_o` at 1 and `rbit_o` at 1.
- R11: A `bus_rst_i` pulse in the same cycle as any other strobe wins. The block ends in the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rst_i | input | 1 | One-cycle pulse: a bus reset was seen |
| byte_vld_i | input | 1 | One-cycle pulse: `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte |
| wbit_vld_i | input | 1 | One-cycle pulse: `wbit_i` holds a master write bit |
| wbit_i | input | 1 | Master write bit |
| rslot_i | input | 1 | One-cycle pulse: a read slot has used `rbit_o` |
| cfg_i | input | 3 | [0] condition polarity, [2:1] condition source select (00 = hidden mode) |
| src_level_i | input | 1 | Level of the selected condition source |
| rbit_o | output | 1 | Level to drive in the next read slot (1 = release) |
| selected_o | output | 1 | Device addressed; memory layer may proceed |
| dropped_o | output | 1 | Device has left the current transaction |

## Verification
A bus reset can arrive in the same cycle as the final bit strobe of a Match ROM or Search ROM, where it would otherwise complete the selection. The bench drives `bus_rst_i` and the 64th write bit in one cycle for both commands. It expects both flags low afterwards, then sends a Skip ROM and checks that `selected_o` rises, which proves the block had returned to waiting for a command. A sweep over every configuration value, both condition levels and every command code checks the hidden-mode and polarity rules against values computed in the bench.

// File: rtl/owr_pkg.sv
package owr_pkg;
  localparam logic [7:0] CODE_READ   = 8'h33;
  localparam logic [7:0] CODE_MATCH  = 8'h55;
  localparam logic [7:0] CODE_SKIP   = 8'hCC;
  localparam logic [7:0] CODE_SEARCH = 8'hF0;
  localparam logic [7:0] CODE_COND   = 8'hEC;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_MATCH, CMD_SKIP, CMD_SEARCH
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_MT, ST_SID, ST_SCMP, ST_SDIR, ST_SEL, ST_OUT
  } st_e;

  function automatic logic [7:0] crc8_lsb(input logic [55:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction
endpackage

// File: rtl/owr_id_rom.sv
module owr_id_rom #(
  parameter logic [7:0]  FAMILY = 8'h12,
  parameter logic [47:0] SERIAL = 48'h0
) (
  output logic [63:0] id_o
);
  localparam logic [55:0] BODY = {SERIAL, FAMILY};
  localparam logic [7:0]  CRC  = owr_pkg::crc8_lsb(BODY);

  assign id_o = {CRC, BODY};
endmodule

// File: rtl/owr_cmd_dec.sv
module owr_cmd_dec
  import owr_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic [2:0] cfg_i,
  input  logic       src_level_i,
  output cmd_e       cmd_o
);
  logic hidden;
  assign hidden = (cfg_i[2:1] == 2'b00);

  always_comb begin
    unique case (byte_i)
      CODE_READ:   cmd_o = hidden ? CMD_NONE : CMD_READ;
      CODE_MATCH:  cmd_o = CMD_MATCH;
      CODE_SKIP:   cmd_o = hidden ? CMD_NONE : CMD_SKIP;
      CODE_SEARCH: cmd_o = hidden ? CMD_NONE : CMD_SEARCH;
      CODE_COND:   cmd_o = (src_level_i == cfg_i[0]) ? CMD_SEARCH : CMD_NONE;
      default:     cmd_o = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/owr_seq.sv
module owr_seq
  import owr_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_rst_i,
  input  logic            byte_vld_i,
  input  cmd_e            cmd_i,
  input  logic            wbit_vld_i,
  input  logic            wbit_i,
  input  logic            rslot_i,
  input  logic [ID_W-1:0] id_i,
  output logic            rbit_o,
  output logic            selected_o,
  output logic            dropped_o
);
  localparam int IDX_W = $clog2(ID_W);

  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  logic             last;
  logic             cur;

  assign last = (idx_q == IDX_W'(ID_W - 1));
  assign cur  = id_i[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (bus_rst_i) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (byte_vld_i) begin
          idx_q <= '0;
          unique case (cmd_i)
            CMD_READ:   st_q <= ST_RD;
            CMD_MATCH:  st_q <= ST_MT;
            CMD_SKIP:   st_q <= ST_SEL;
            CMD_SEARCH: st_q <= ST_SID;
            default:    st_q <= ST_OUT;
          endcase
        end
        ST_RD: if (rslot_i) begin
          if (last) st_q <= ST_SEL;
          else      idx_q <= idx_q + IDX_W'(1);
        end
        ST_MT: if (wbit_vld_i) begin
          if (wbit_i != cur) st_q <= ST_OUT;
          else if (last)     st_q <= ST_SEL;
          else               idx_q <= idx_q + IDX_W'(1);
        end
        ST_SID:  if (rslot_i) st_q <= ST_SCMP;
        ST_SCMP: if (rslot_i) st_q <= ST_SDIR;
        ST_SDIR: if (wbit_vld_i) begin
          if (wbit_i != cur) st_q <= ST_OUT;
          else if (last)     st_q <= ST_SEL;
          else begin
            st_q  <= ST_SID;
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_RD, ST_SID: rbit_o = cur;
      ST_SCMP:       rbit_o = ~cur;
      default:       rbit_o = 1'b1;
    endcase
  end

  assign selected_o = (st_q == ST_SEL);
  assign dropped_o  = (st_q == ST_OUT);

  assert_bus_rst_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (!selected_o && !dropped_o && rbit_o));

  assert_drop_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dropped_o && !bus_rst_i) |=> (dropped_o && rbit_o));

  assert_sel_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (selected_o && !bus_rst_i) |=> (selected_o && rbit_o));

  assert_skip_selects_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && byte_vld_i && cmd_i == CMD_SKIP && !bus_rst_i) |=> selected_o);

  assert_unanswered_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && byte_vld_i && cmd_i == CMD_NONE && !bus_rst_i) |=> dropped_o);

  assert_cmp_follows_id_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SID && rslot_i && !bus_rst_i) |=> (rbit_o == !$past(rbit_o)));
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer #(
  parameter logic [7:0]  FAMILY = 8'h12,
  parameter logic [47:0] SERIAL = 48'hA1B2_C3D4_E5F6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_rst_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       wbit_vld_i,
  input  logic       wbit_i,
  input  logic       rslot_i,
  input  logic [2:0] cfg_i,
  input  logic       src_level_i,
  output logic       rbit_o,
  output logic       selected_o,
  output logic       dropped_o
);
  localparam int ID_W = 64;

  logic [ID_W-1:0] id;
  owr_pkg::cmd_e   cmd;

  owr_id_rom #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (.id_o(id));

  owr_cmd_dec u_dec (
    .byte_i     (byte_i),
    .cfg_i      (cfg_i),
    .src_level_i(src_level_i),
    .cmd_o      (cmd)
  );

  owr_seq #(.ID_W(ID_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_i (bus_rst_i),
    .byte_vld_i(byte_vld_i),
    .cmd_i     (cmd),
    .wbit_vld_i(wbit_vld_i),
    .wbit_i    (wbit_i),
    .rslot_i   (rslot_i),
    .id_i      (id),
    .rbit_o    (rbit_o),
    .selected_o(selected_o),
    .dropped_o (dropped_o)
  );
endmodule

// File: tb/owr_rom_layer_tb.sv
module owr_rom_layer_tb;
  localparam logic [47:0] SER = 48'hA1B2_C3D4_E5F6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_rst_i = 0, byte_vld_i = 0, wbit_vld_i = 0, wbit_i = 0, rslot_i = 0, src_level_i = 0;
  logic [7:0] byte_i = 8'h00;
  logic [2:0] cfg_i = 3'b010;
  logic rbit_o, selected_o, dropped_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [63:0] exp_id;

  always #10 clk = ~clk;

  owr_rom_layer #(.SERIAL(SER)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_i(bus_rst_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .wbit_vld_i(wbit_vld_i), .wbit_i(wbit_i), .rslot_i(rslot_i),
    .cfg_i(cfg_i), .src_level_i(src_level_i), .rbit_o(rbit_o),
    .selected_o(selected_o), .dropped_o(dropped_o)
  );

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic f;
      f = r[0] ^ d[i];
      r = {1'b0, r[7:1]} ^ (f ? 8'h8C : 8'h00);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic flags(input string tag, input logic s, input logic d);
    chk(tag, {62'd0, selected_o, dropped_o}, {62'd0, s, d});
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_i = b; byte_vld_i = 1; @(negedge clk); byte_vld_i = 0;
  endtask

  task automatic wr_bit(input logic b);
    wbit_i = b; wbit_vld_i = 1; @(negedge clk); wbit_vld_i = 0;
  endtask

  task automatic rd_slot(output logic v);
    v = rbit_o; rslot_i = 1; @(negedge clk); rslot_i = 0;
  endtask

  task automatic brst;
    bus_rst_i = 1; @(negedge clk); bus_rst_i = 0;
  endtask

  // search; mis = bit index where master disagrees, -1 for none
  task automatic do_search(input int mis, input string tag);
    logic a, c;
    int errs = 0;
    for (int k = 0; k < 64; k++) begin
      rd_slot(a);
      rd_slot(c);
      if (a !== exp_id[k] || c !== ~exp_id[k]) errs++;
      wr_bit(k == mis ? ~exp_id[k] : exp_id[k]);
      if (k == mis) break;
    end
    chk({tag, " id/complement bits"}, 64'(errs), 64'd0);
  endtask

  task automatic do_match(input int mis);
    for (int k = 0; k < 64; k++) begin
      wr_bit(k == mis ? ~exp_id[k] : exp_id[k]);
      if (k == mis) break;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [63:0] got;
    exp_id = {ref_crc({SER, 8'h12}), SER, 8'h12};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset rbit", 64'(rbit_o), 64'd1);
    flags("R1 reset flags", 0, 0);
    rst_ni = 1; @(negedge clk);
    flags("R1 after reset release", 0, 0);

    // R3 / R2: read ROM
    send_byte(8'h33);
    for (int k = 0; k < 64; k++) begin
      rd_slot(v); got[k] = v;
    end
    chk("R3 read rom bits", got, exp_id);
    chk("R2 family field", 64'(got[7:0]), 64'h12);
    chk("R2 serial field", 64'(got[55:8]), 64'(SER));
    chk("R2 crc field", 64'(got[63:56]), 64'(ref_crc(got[55:0])));
    flags("R3 selected after 64 slots", 1, 0);

    // R10: traffic while selected
    send_byte(8'hF0); wr_bit(0); rd_slot(v);
    chk("R10 rbit while selected", 64'(v), 64'd1);
    chk("R10 rbit after strobes", 64'(rbit_o), 64'd1);
    flags("R10 still selected", 1, 0);

    brst();
    chk("R1 bus reset rbit", 64'(rbit_o), 64'd1);
    flags("R1 bus reset flags", 0, 0);

    // R4
    send_byte(8'hCC);
    flags("R4 skip selects", 1, 0);
    brst();

    // R5 match ok and mismatch sweep
    send_byte(8'h55); do_match(-1);
    flags("R5 match full", 1, 0);
    for (int m = 0; m < 64; m += 9) begin
      brst();
      send_byte(8'h55); do_match(m);
      flags($sformatf("R5 match mismatch at %0d", m), 0, 1);
    end
    do_match(64);
    flags("R5 mismatch at bit 63 ends dropped", 0, 1);
    brst(); send_byte(8'h55); do_match(63);
    flags("R5 mismatch last bit", 0, 1);
    // R9: ignored after drop
    send_byte(8'hCC); wr_bit(1); rd_slot(v);
    chk("R9 rbit while dropped", 64'(v), 64'd1);
    chk("R9 rbit after strobes", 64'(rbit_o), 64'd1);
    flags("R9 still dropped", 0, 1);
    brst();

    // R6 search
    send_byte(8'hF0); do_search(-1, "R6 full");
    flags("R6 search completes", 1, 0);
    for (int m = 0; m < 64; m += 21) begin
      brst(); send_byte(8'hF0); do_search(m, "R6 mismatch");
      flags($sformatf("R6 search mismatch at %0d", m), 0, 1);
    end

    // R7 conditional search, polarity x level
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 2; s++) begin
        brst(); cfg_i = {2'b01, 1'(p)}; src_level_i = 1'(s);
        send_byte(8'hEC);
        if (p == s) begin
          flags($sformatf("R7 cond pol=%0d lvl=%0d start", p, s), 0, 0);
          do_search(-1, "R7 cond");
          flags("R7 cond search completes", 1, 0);
        end else
          flags($sformatf("R7 cond pol=%0d lvl=%0d drop", p, s), 0, 1);
      end
    end

    // R8 sweep over config, level and codes
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int j = 0; j < 7; j++) begin
          logic [7:0] code;
          logic hid, ed, es;
          code = (j == 0) ? 8'h33 : (j == 1) ? 8'h55 : (j == 2) ? 8'hCC :
                 (j == 3) ? 8'hF0 : (j == 4) ? 8'hEC : (j == 5) ? 8'hA5 : 8'h00;
          brst(); cfg_i = 3'(c); src_level_i = 1'(s);
          hid = (c[2:1] == 2'b00);
          case (code)
            8'h33, 8'hCC, 8'hF0: ed = hid;
            8'h55:               ed = 0;
            8'hEC:               ed = (1'(s) != 1'(c));
            default:             ed = 1;
          endcase
          es = (code == 8'hCC) && !hid;
          send_byte(code);
          flags($sformatf("R8 cfg=%0d lvl=%0d code=%h", c, s, code), es, ed);
        end
      end
    end
    cfg_i = 3'b010;

    // R11: bus reset colliding with final match bit
    brst(); send_byte(8'h55);
    for (int k = 0; k < 63; k++) wr_bit(exp_id[k]);
    wbit_i = exp_id[63]; wbit_vld_i = 1; bus_rst_i = 1;
    @(negedge clk); wbit_vld_i = 0; bus_rst_i = 0;
    flags("R11 reset beats last match bit", 0, 0);
    send_byte(8'hCC);
    flags("R11 idle after collision (match)", 1, 0);

    // R11: bus reset colliding with final search write bit
    brst(); send_byte(8'hF0);
    for (int k = 0; k < 63; k++) begin
      rd_slot(v); rd_slot(v); wr_bit(exp_id[k]);
    end
    rd_slot(v); rd_slot(v);
    wbit_i = exp_id[63]; wbit_vld_i = 1; bus_rst_i = 1;
    @(negedge clk); wbit_vld_i = 0; bus_rst_i = 0;
    flags("R11 reset beats last search bit", 0, 0);
    chk("R11 rbit after collision", 64'(rbit_o), 64'd1);
    send_byte(8'hCC);
    flags("R11 idle after collision (search)", 1, 0);

    // R11: bus reset with a command byte
    brst();
    byte_i = 8'hCC; byte_vld_i = 1; bus_rst_i = 1;
    @(negedge clk); byte_vld_i = 0; bus_rst_i = 0;
    flags("R11 reset beats command byte", 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule